// File: doc/BRIEF.md
# USB Type-C Source Connection Controller

This block is the source-side connection decision logic for one USB Type-C port. Each cycle it receives raw comparator bits for the two CC pins and reduces each pin to one of three terminations: Open, Rd (a sink's pull-down) or Ra (the VCONN load of an electronically marked cable). From the pair of terminations it decides whether nothing, a sink, a powered cable alone, or a powered cable with a sink is present. It then drives the VBUS enable, the VCONN enable and the pin VCONN goes to, the plug orientation, and a mask of the pins being watched.

A new termination pair must stay unchanged for a debounce count before it is acted on. A disconnect is registered only when the watched pin reads Open without a break for the tCC interval. The Open/Rd comparator used for every decision is the one that matches the active pull-up current, which is either 1.5 A or 3.0 A. The higher current is granted only while a sink is powered, the host asks for it, and the regulator reports a settled 5 V output. Both time limits are parameters counted in clock cycles.

Top module: `tc_src_ctrl`

## Requirements
- R1: Each pin's class comes from its Open-boundary bit (1 = level above the Rd/Open boundary) and its Ra-boundary bit (1 = level below the Ra boundary). The pair (0,0) is Rd, (0,1) is Ra, (1,0) is Open, and the contradictory (1,1) is taken as Open.
- R2: With both pins Open, or with Rd on both pins, or with Ra on both pins, the block stays unattached (conn_state 0). VBUS and VCONN stay off and mon_pins is 2'b11.
- R3: Rd on one pin with Open on the other gives conn_state 1. VBUS turns on and VCONN stays off. mon_pins is one-hot on the Rd pin (bit 0 = CC1, bit 1 = CC2), and orient_cc2 is 1 exactly when the Rd pin is CC2.
- R4: Ra on one pin with Open on the other gives conn_state 2. VBUS and VCONN stay off and mon_pins is 2'b11.
- R5: Ra on one pin with Rd on the other gives conn_state 3. VBUS and VCONN turn on, vconn_cc2 names the Ra pin, and mon_pins is one-hot on the Rd pin. While in this state, any level on the Ra pin has no effect.
- R6: A new attach pair must be seen unchanged on ATT_DB consecutive rising edges. The outputs change right after the ATT_DB-th edge, and a shorter run has no effect.
- R7: In states 1 and 3, a detach happens when the Rd pin reads Open on TCC consecutive edges. At the TCC-th edge, state, VBUS, VCONN and rp_3a all drop together and mon_pins returns to 2'b11. A shorter run has no effect.
- R8: rp_3a is 1 on the edge after which the block is in state 1 or 3 while host_rp3a_req and vreg_5v_ok are both 1. In every other case, and after reset, rp_3a is 0 (1.5 A).
- R9: The Open-boundary bit used in R1 is cc_open_30 while rp_3a is 1, and cc_open_15 otherwise.
- R10: From state 2, Rd appearing on the Open pin, with the Ra pin still Ra for ATT_DB edges, moves the block to state 3. The Ra pin reading Open for TCC edges returns it to state 0.
- R11: After reset, all outputs are 0 except mon_pins, which is 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cc_open_15 | input | 2 | Per pin: above the Rd/Open boundary used at 1.5 A (bit 0 = CC1) |
| cc_open_30 | input | 2 | Per pin: above the Rd/Open boundary used at 3.0 A |
| cc_below_ra | input | 2 | Per pin: below the Ra boundary |
| host_rp3a_req | input | 1 | Host request for the 3.0 A pull-up level |
| vreg_5v_ok | input | 1 | Regulator reports a settled 5 V output |
| conn_state | output | 2 | 0 none, 1 sink, 2 cable only, 3 cable and sink |
| vbus_en | output | 1 | VBUS power enable |
| vconn_en | output | 1 | VCONN power enable |
| vconn_cc2 | output | 1 | VCONN routed to CC2 (valid with vconn_en) |
| orient_cc2 | output | 1 | Sink Rd is on CC2 |
| mon_pins | output | 2 | Pins being watched for attach or detach |
| rp_3a | output | 1 | Active pull-up level: 1 = 3.0 A, 0 = 1.5 A |

## Verification
The hardest case to reach is a pin whose two Open-boundary comparators disagree while the 3.0 A level is active. Reaching it requires a sink attached, the host request, and the regulator flag all held before the split levels are applied. Here the 1.5 A comparator must be ignored and the pin must still count as Rd. The stimulus gets there with a directed sequence, and the random phase also drives the two boundary bits independently some of the time while request and regulator status toggle. The upgrade from cable-only to cable-plus-sink, with VCONN kept on the original Ra pin, is reached by a directed attach of Ra followed by Rd on the opposite pin.

// File: rtl/tc_src_pkg.sv
package tc_src_pkg;

  typedef enum logic [1:0] {
    CLS_OPEN = 2'd0,
    CLS_RD   = 2'd1,
    CLS_RA   = 2'd2
  } cc_cls_e;

  typedef enum logic [1:0] {
    CONN_NONE  = 2'd0,
    CONN_SINK  = 2'd1,
    CONN_CABLE = 2'd2,
    CONN_BOTH  = 2'd3
  } conn_e;

  // pin: Rd pin for SINK/BOTH, Ra pin for CABLE, 0 otherwise
  typedef struct packed {
    conn_e conn;
    logic  pin;
  } cand_t;

  function automatic cc_cls_e cls_decode(input logic above_open, input logic below_ra);
    if (above_open)    return CLS_OPEN;
    else if (below_ra) return CLS_RA;
    else               return CLS_RD;
  endfunction

  function automatic cand_t pair_target(input cc_cls_e c1, input cc_cls_e c2);
    cand_t t;
    t.conn = CONN_NONE;
    t.pin  = 1'b0;
    if      (c1 == CLS_RD   && c2 == CLS_OPEN) begin t.conn = CONN_SINK;  t.pin = 1'b0; end
    else if (c1 == CLS_OPEN && c2 == CLS_RD)   begin t.conn = CONN_SINK;  t.pin = 1'b1; end
    else if (c1 == CLS_RA   && c2 == CLS_OPEN) begin t.conn = CONN_CABLE; t.pin = 1'b0; end
    else if (c1 == CLS_OPEN && c2 == CLS_RA)   begin t.conn = CONN_CABLE; t.pin = 1'b1; end
    else if (c1 == CLS_RD   && c2 == CLS_RA)   begin t.conn = CONN_BOTH;  t.pin = 1'b0; end
    else if (c1 == CLS_RA   && c2 == CLS_RD)   begin t.conn = CONN_BOTH;  t.pin = 1'b1; end
    return t;
  endfunction

endpackage

// File: rtl/tc_cc_classify.sv
module tc_cc_classify
  import tc_src_pkg::*;
(
  input  logic    open_15,
  input  logic    open_30,
  input  logic    below_ra,
  input  logic    rp_hi,
  output cc_cls_e cls
);
  logic open_sel;
  // R9: boundary follows the active pull-up level
  assign open_sel = rp_hi ? open_30 : open_15;
  assign cls      = cls_decode(open_sel, below_ra);
endmodule

// File: rtl/tc_hold_cnt.sv
module tc_hold_cnt #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          first;

  assign first = restart || !run_q;
  assign done  = run && !first && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= run;
      if (!run)                      cnt_q <= '0;
      else if (first)                cnt_q <= CW'(1);
      else if (cnt_q != CW'(LIMIT))  cnt_q <= cnt_q + CW'(1);
    end
  end

  initial begin
    limit_ok_chk: assert (LIMIT >= 2);
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LIMIT));
endmodule

// File: rtl/tc_src_ctrl.sv
module tc_src_ctrl
  import tc_src_pkg::*;
#(
  parameter int ATT_DB = 8,
  parameter int TCC    = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cc_open_15,
  input  logic [1:0] cc_open_30,
  input  logic [1:0] cc_below_ra,
  input  logic       host_rp3a_req,
  input  logic       vreg_5v_ok,
  output logic [1:0] conn_state,
  output logic       vbus_en,
  output logic       vconn_en,
  output logic       vconn_cc2,
  output logic       orient_cc2,
  output logic [1:0] mon_pins,
  output logic       rp_3a
);
  localparam int NPIN = 2;

  cc_cls_e cls [NPIN];
  cand_t   cand, cand_q;
  conn_e   conn_q, conn_d;
  logic    pin_q, pin_d;
  logic    rp_q, rp_d;
  logic    att_run, att_restart, att_done;
  logic    det_run, det_done;
  logic    watched_open;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    tc_cc_classify u_cls (
      .open_15  (cc_open_15[p]),
      .open_30  (cc_open_30[p]),
      .below_ra (cc_below_ra[p]),
      .rp_hi    (rp_q),
      .cls      (cls[p])
    );
  end

  assign cand = pair_target(cls[0], cls[1]);

  // attach: new pair from idle, or sink joining a cable-only state
  assign att_run = (conn_q == CONN_NONE  && cand.conn != CONN_NONE) ||
                   (conn_q == CONN_CABLE && cand.conn == CONN_BOTH && cand.pin != pin_q);
  assign att_restart = (cand != cand_q);

  tc_hold_cnt #(.LIMIT(ATT_DB)) u_att (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (att_run),
    .restart (att_restart),
    .done    (att_done)
  );

  // detach: only the pin held in pin_q is watched
  assign watched_open = (cls[pin_q] == CLS_OPEN);
  assign det_run      = (conn_q != CONN_NONE) && watched_open;

  tc_hold_cnt #(.LIMIT(TCC)) u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (det_run),
    .restart (1'b0),
    .done    (det_done)
  );

  always_comb begin
    conn_d = conn_q;
    pin_d  = pin_q;
    if (det_done) begin
      conn_d = CONN_NONE;
      pin_d  = 1'b0;
    end else if (att_done) begin
      conn_d = cand.conn;
      pin_d  = cand.pin;
    end
    rp_d = (conn_d == CONN_SINK || conn_d == CONN_BOTH) && host_rp3a_req && vreg_5v_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conn_q <= CONN_NONE;
      pin_q  <= 1'b0;
      rp_q   <= 1'b0;
      cand_q <= '0;
    end else begin
      conn_q <= conn_d;
      pin_q  <= pin_d;
      rp_q   <= rp_d;
      cand_q <= cand;
    end
  end

  assign conn_state = conn_q;
  assign vbus_en    = (conn_q == CONN_SINK) || (conn_q == CONN_BOTH);
  assign vconn_en   = (conn_q == CONN_BOTH);
  assign vconn_cc2  = vconn_en && !pin_q;
  assign orient_cc2 = vbus_en && pin_q;
  assign mon_pins   = vbus_en ? (pin_q ? 2'b10 : 2'b01) : 2'b11;
  assign rp_3a      = rp_q;

  // R3
  vbus_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vbus_en) |-> $past(att_done));

  // R7
  vbus_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vbus_en) |-> ($past(det_done) && !vconn_en && !rp_3a && mon_pins == 2'b11));

  // R5
  vconn_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vconn_en |-> (vbus_en && $countones(mon_pins) == 1));

  // R8
  rp_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rp_3a |-> (vbus_en && $past(host_rp3a_req && vreg_5v_ok)));
endmodule

// File: tb/tc_src_ctrl_bench.sv
module tc_src_ctrl_bench;
  localparam int ATT_DB = 8;
  localparam int TCC    = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] o15 = 2'b11, o30 = 2'b11, ra = 2'b00;
  logic       req = 1'b0, ok = 1'b0;
  logic [1:0] conn_state, mon_pins;
  logic       vbus_en, vconn_en, vconn_cc2, orient_cc2, rp_3a;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tc_src_ctrl #(.ATT_DB(ATT_DB), .TCC(TCC)) u_tc_src_ctrl (
    .clk(clk), .rst_n(rst_n), .cc_open_15(o15), .cc_open_30(o30),
    .cc_below_ra(ra), .host_rp3a_req(req), .vreg_5v_ok(ok),
    .conn_state(conn_state), .vbus_en(vbus_en), .vconn_en(vconn_en),
    .vconn_cc2(vconn_cc2), .orient_cc2(orient_cc2), .mon_pins(mon_pins),
    .rp_3a(rp_3a)
  );

  // reference model: classes 0 open, 1 rd, 2 ra
  int m_conn = 0, m_pin = 0, m_rp = 0, a_cnt = 0, d_cnt = 0;
  int p_tc = 0, p_tp = 0;
  bit p_arun = 0, p_drun = 0;

  function automatic int cls_of(bit b15, bit b30, bit bra, int rp);
    bit over = (rp != 0) ? b30 : b15;
    if (over) return 0;
    return bra ? 2 : 1;
  endfunction

  always @(posedge clk) begin : model
    int c1, c2, tc, tp, nc, np, wc;
    bit arun, drun, adone, ddone;
    if (!rst_n) begin
      m_conn = 0; m_pin = 0; m_rp = 0; a_cnt = 0; d_cnt = 0;
      p_tc = 0; p_tp = 0; p_arun = 0; p_drun = 0;
    end else begin
      c1 = cls_of(o15[0], o30[0], ra[0], m_rp);
      c2 = cls_of(o15[1], o30[1], ra[1], m_rp);
      tc = 0; tp = 0;
      if (c1 == 1 && c2 == 0) begin tc = 1; tp = 0; end
      if (c1 == 0 && c2 == 1) begin tc = 1; tp = 1; end
      if (c1 == 2 && c2 == 0) begin tc = 2; tp = 0; end
      if (c1 == 0 && c2 == 2) begin tc = 2; tp = 1; end
      if (c1 == 1 && c2 == 2) begin tc = 3; tp = 0; end
      if (c1 == 2 && c2 == 1) begin tc = 3; tp = 1; end
      arun = (m_conn == 0 && tc != 0) || (m_conn == 2 && tc == 3 && tp != m_pin);
      adone = 0;
      if (arun) begin
        if (p_arun && tc == p_tc && tp == p_tp) a_cnt++; else a_cnt = 1;
        adone = (a_cnt == ATT_DB);
      end else a_cnt = 0;
      wc = (m_pin != 0) ? c2 : c1;
      drun = (m_conn != 0) && (wc == 0);
      ddone = 0;
      if (drun) begin
        if (p_drun) d_cnt++; else d_cnt = 1;
        ddone = (d_cnt == TCC);
      end else d_cnt = 0;
      nc = m_conn; np = m_pin;
      if (ddone) begin nc = 0; np = 0; end
      else if (adone) begin nc = tc; np = tp; end
      m_rp = ((nc == 1 || nc == 3) && req && ok) ? 1 : 0;
      m_conn = nc; m_pin = np;
      p_tc = tc; p_tp = tp; p_arun = arun; p_drun = drun;
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // continuous comparison against the model, tagged by expected state
  always @(negedge clk) begin : cmp
    int ev, em;
    string tag;
    if (rst_n && !finished) begin
      case (m_conn)
        0: tag = "R2"; 1: tag = "R3"; 2: tag = "R4"; default: tag = "R5";
      endcase
      ev = (m_conn == 1 || m_conn == 3) ? 1 : 0;
      em = ev ? ((m_pin != 0) ? 2 : 1) : 3;
      chk({tag, " conn"}, conn_state, m_conn);
      chk({tag, " vbus"}, vbus_en, ev);
      chk({tag, " vconn"}, vconn_en, (m_conn == 3) ? 1 : 0);
      chk({tag, " vconn_pin"}, vconn_cc2, (m_conn == 3 && m_pin == 0) ? 1 : 0);
      chk({tag, " orient"}, orient_cc2, (ev && m_pin != 0) ? 1 : 0);
      chk({tag, " mon"}, mon_pins, em);
      chk("R8 rp", rp_3a, m_rp);
    end
  end

  task automatic set_pin(int p, int c);
    case (c)
      0: begin o15[p] = 1; o30[p] = 1; ra[p] = 0; end
      1: begin o15[p] = 0; o30[p] = 0; ra[p] = 0; end
      2: begin o15[p] = 0; o30[p] = 0; ra[p] = 1; end
      default: begin o15[p] = 1; o30[p] = 1; ra[p] = 1; end
    endcase
  endtask

  task automatic drive(int c1, int c2);
    set_pin(0, c1);
    set_pin(1, c2);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin : stim
    void'($urandom(32'h5eed_c0de));
    step(3);
    rst_n = 1'b1;
    step(1);
    // R11 reset state
    chk("R11 conn", conn_state, 0);
    chk("R11 vbus", vbus_en, 0);
    chk("R11 mon", mon_pins, 3);
    chk("R11 rp", rp_3a, 0);

    // R6 attach debounce boundary, then R3
    drive(1, 0); step(ATT_DB - 1);
    chk("R6 early", conn_state, 0);
    step(1);
    chk("R6 commit", conn_state, 1);
    chk("R3 mon cc1", mon_pins, 1);

    // R7 short open ignored, full tCC detaches
    drive(0, 0); step(TCC - 1);
    chk("R7 short", vbus_en, 1);
    drive(1, 0); step(1);
    drive(0, 0); step(TCC - 1);
    chk("R7 restart", vbus_en, 1);
    step(1);
    chk("R7 drop", vbus_en, 0);
    chk("R7 mon", mon_pins, 3);

    // R6 glitch restarts the count; R3 on CC2
    drive(0, 1); step(ATT_DB - 1);
    drive(0, 0); step(1);
    drive(0, 1); step(ATT_DB - 1);
    chk("R6 glitch", conn_state, 0);
    step(1);
    chk("R3 orient", orient_cc2, 1);
    chk("R3 mon cc2", mon_pins, 2);

    // R8 grant gated by regulator status
    req = 1; ok = 0; step(5);
    chk("R8 wait", rp_3a, 0);
    ok = 1; step(1);
    chk("R8 grant", rp_3a, 1);
    // R9 split boundary bits: 1.5 A comparator says open, 3.0 A says Rd
    o15[1] = 1; o30[1] = 0; ra[1] = 0; step(TCC + 3);
    chk("R9 hold", vbus_en, 1);
    o30[1] = 1; step(TCC);
    chk("R9 drop", vbus_en, 0);
    chk("R8 clear", rp_3a, 0);
    req = 0; ok = 0;

    // R4 then R10 upgrade, R5 Ra pin ignored
    drive(2, 0); step(ATT_DB);
    chk("R4 conn", conn_state, 2);
    chk("R4 vbus", vbus_en, 0);
    drive(2, 1); step(ATT_DB);
    chk("R10 up", conn_state, 3);
    chk("R5 vconn", vconn_en, 1);
    chk("R5 vconn cc1", vconn_cc2, 0);
    drive(0, 1); step(TCC + 5);
    chk("R5 ignore Ra", conn_state, 3);
    drive(0, 0); step(TCC);
    chk("R7 both drop", vconn_en, 0);

    // R10 cable removal
    drive(0, 2); step(ATT_DB);
    chk("R10 cable", conn_state, 2);
    drive(0, 0); step(TCC);
    chk("R10 removed", conn_state, 0);

    // R2 unsupported pairs
    drive(1, 1); step(ATT_DB + 3);
    chk("R2 rdrd", vbus_en, 0);
    drive(2, 2); step(ATT_DB + 3);
    chk("R2 rara", conn_state, 0);

    // R1 contradictory bits read as Open
    drive(3, 0); step(ATT_DB + 3);
    chk("R1 contra", conn_state, 0);
    drive(2, 3); step(ATT_DB);
    chk("R1 ra", conn_state, 2);
    drive(0, 0); step(TCC + 2);

    // random phase
    for (int s = 0; s < 400; s++) begin
      drive($urandom_range(0, 3), $urandom_range(0, 3));
      if ($urandom_range(0, 4) == 0) begin
        int p = $urandom_range(0, 1);
        o15[p] = $urandom_range(0, 1);
        o30[p] = $urandom_range(0, 1);
      end
      req = $urandom_range(0, 1);
      ok  = ($urandom_range(0, 3) != 0);
      step($urandom_range(1, 25));
    end
    summary();
  end
endmodule